// File: doc/BRIEF.md
# Future-File Result Tracker with In-Order Retirement

This block holds two copies of a small register set and a circular queue of in-flight instructions. When an instruction is issued, it takes the next queue slot in program order and gets a slot tag. When its result arrives, the result goes straight into the speculative copy, the future file. Operand reads for new instructions come from that copy, so a result can be used at once even while older instructions are still outstanding. The committed copy, the architectural file, changes only when the oldest queue entry retires.

Each queue slot holds a destination register, a result, an exception flag, a completed flag and the instruction address. Retirement takes at most one entry per cycle, from the head of the queue. If the head entry completed with an exception, it does not retire. Instead, the whole committed copy is loaded back into the speculative copy, every slot is dropped, and the faulting address is reported. The queue depth must be a power of two and at least 2.

Top module: `future_file_rob`

## Requirements
- R1: After reset, every register in both copies reads zero, `iss_ready` is 1, the first issued tag is 0, and `cmt_valid` and `flush_valid` are 0.
- R2: Issued instructions get tags in strict increasing order, wrapping modulo DEPTH. When DEPTH entries are in flight, `iss_ready` is 0, and an issue attempt changes neither `iss_tag` nor the queue contents.
- R3: A completion writes its value into the speculative copy, and `rd_data` returns it from the next cycle. This holds even while older entries are still incomplete. The committed copy does not change until a retirement.
- R4: When a completion and a read of the same register fall in the same cycle, `rd_data` returns the completing value in that cycle.
- R5: An older completion does not overwrite the speculative value of a register if a younger entry with the same destination has already completed.
- R6: Only the head entry retires, and only when it is completed without an exception; at most one entry retires per cycle. The cycle after the retirement, `cmt_valid` is 1, `cmt_dest`/`cmt_value` hold the entry's destination and result, and `arch_data` shows the new value.
- R7: When the head entry is completed with an exception, then in the next cycle `flush_valid` is 1 and `flush_pc` holds its address. From then on the speculative copy equals the committed copy, `iss_ready` is 1 and the next issued tag is 0.
- R8: A completion that names a slot not currently allocated changes neither register copy and causes no retirement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Issue request |
| iss_dest | input | AW | Destination register of the issued instruction |
| iss_pc | input | PCW | Address of the issued instruction |
| iss_ready | output | 1 | A slot is free and issue is accepted this cycle |
| iss_tag | output | TW | Slot tag given to an issue in this cycle |
| cmp_valid | input | 1 | Result delivery |
| cmp_tag | input | TW | Slot the result belongs to |
| cmp_value | input | DW | Result value |
| cmp_exc | input | 1 | The instruction raised an exception |
| rd_addr | input | AW | Operand read address (speculative copy) |
| rd_data | output | DW | Operand read data, with a bypass from a same-cycle completion |
| arch_addr | input | AW | Read address into the committed copy |
| arch_data | output | DW | Committed register value |
| cmt_valid | output | 1 | An entry retired at the previous edge |
| cmt_dest | output | AW | Destination register of the retired entry |
| cmt_value | output | DW | Value of the retired entry |
| flush_valid | output | 1 | A flush happened at the previous edge |
| flush_pc | output | PCW | Address of the faulting instruction |

## Verification
A wrong internal state shows up quickly at the ports. A wrongly set completed flag or a wrong head pointer makes `cmt_valid` appear one cycle early, or carry the wrong destination and value, and the in-order scoreboard catches that at the next retirement. A stale or wrongly shadowed speculative entry shows on `rd_data` in the first read after the completion. A bad reload on flush shows as a mismatch between `rd_data` and the committed values in the cycle after `flush_valid`. A corrupted slot count shows as `iss_ready` going low with too few or too many entries in flight, or as a tag that does not restart at 0 after a flush.

// File: rtl/ffrob_pkg.sv
package ffrob_pkg;
  typedef enum logic [1:0] {
    HEAD_WAIT   = 2'd0,
    HEAD_RETIRE = 2'd1,
    HEAD_FLUSH  = 2'd2
  } head_act_e;
endpackage

// File: rtl/ffrob_regfile.sv
module ffrob_regfile #(
  parameter int NREG = 8,
  parameter int DW   = 16,
  localparam int AW  = $clog2(NREG)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic [AW-1:0]        waddr,
  input  logic [DW-1:0]        wdata,
  input  logic                 load_en,
  input  logic [NREG*DW-1:0]   load_all,
  input  logic [AW-1:0]        raddr,
  output logic [DW-1:0]        rdata,
  output logic [NREG*DW-1:0]   all_q
);
  logic [DW-1:0] mem [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else if (load_en) begin
      for (int i = 0; i < NREG; i++) mem[i] <= load_all[i*DW +: DW];
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];

  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign all_q[g*DW +: DW] = mem[g];
  end
endmodule

// File: rtl/ffrob_queue.sv
module ffrob_queue
  import ffrob_pkg::*;
#(
  parameter int NREG  = 8,
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  parameter int PCW   = 16,
  localparam int AW   = $clog2(NREG),
  localparam int TW   = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            iss_valid,
  input  logic [AW-1:0]   iss_dest,
  input  logic [PCW-1:0]  iss_pc,
  output logic            iss_ready,
  output logic [TW-1:0]   iss_tag,
  input  logic            cmp_valid,
  input  logic [TW-1:0]   cmp_tag,
  input  logic [DW-1:0]   cmp_value,
  input  logic            cmp_exc,
  output logic            ff_we,
  output logic [AW-1:0]   ff_waddr,
  output logic [DW-1:0]   ff_wdata,
  output logic            commit_fire,
  output logic [AW-1:0]   commit_dest,
  output logic [DW-1:0]   commit_value,
  output logic            flush_fire,
  output logic [PCW-1:0]  flush_pc,
  output logic [TW:0]     count_q
);
  logic [DEPTH-1:0] vld_q, done_q, exc_q;
  logic [AW-1:0]    dest_q [DEPTH];
  logic [DW-1:0]    val_q  [DEPTH];
  logic [PCW-1:0]   pc_q   [DEPTH];
  logic [TW-1:0]    head_q, tail_q;

  head_act_e act;
  logic      iss_ok, cmp_ok, shadowed;
  logic [TW-1:0] age_c, age_j;

  always_comb begin
    act = HEAD_WAIT;
    if (vld_q[head_q] && done_q[head_q])
      act = exc_q[head_q] ? HEAD_FLUSH : HEAD_RETIRE;
  end

  assign commit_fire  = (act == HEAD_RETIRE);
  assign flush_fire   = (act == HEAD_FLUSH);
  assign commit_dest  = dest_q[head_q];
  assign commit_value = val_q[head_q];
  assign flush_pc     = pc_q[head_q];

  assign iss_ready = (count_q != (TW+1)'(DEPTH)) && !flush_fire;
  assign iss_tag   = tail_q;
  assign iss_ok    = iss_valid && iss_ready;
  assign cmp_ok    = cmp_valid && vld_q[cmp_tag] && !flush_fire;

  // A younger, already completed writer of the same register owns the
  // speculative value; an older result arriving late must not replace it.
  always_comb begin
    shadowed = 1'b0;
    age_c    = cmp_tag - head_q;
    age_j    = '0;
    for (int j = 0; j < DEPTH; j++) begin
      age_j = TW'(j) - head_q;
      if (vld_q[j] && done_q[j] && (dest_q[j] == dest_q[cmp_tag]) && (age_j > age_c))
        shadowed = 1'b1;
    end
  end

  assign ff_we    = cmp_ok && !shadowed;
  assign ff_waddr = dest_q[cmp_tag];
  assign ff_wdata = cmp_value;

  always_ff @(posedge clk) begin
    if (rst || flush_fire) begin
      vld_q   <= '0;
      done_q  <= '0;
      exc_q   <= '0;
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      if (iss_ok) begin
        vld_q[tail_q]  <= 1'b1;
        done_q[tail_q] <= 1'b0;
        exc_q[tail_q]  <= 1'b0;
        dest_q[tail_q] <= iss_dest;
        pc_q[tail_q]   <= iss_pc;
        tail_q         <= tail_q + 1'b1;
      end
      if (cmp_ok) begin
        done_q[cmp_tag] <= 1'b1;
        exc_q[cmp_tag]  <= cmp_exc;
        val_q[cmp_tag]  <= cmp_value;
      end
      if (commit_fire) begin
        vld_q[head_q] <= 1'b0;
        head_q        <= head_q + 1'b1;
      end
      count_q <= count_q + (TW+1)'(iss_ok) - (TW+1)'(commit_fire);
    end
  end
endmodule

// File: rtl/future_file_rob.sv
module future_file_rob #(
  parameter int NREG  = 8,
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  parameter int PCW   = 16,
  localparam int AW   = $clog2(NREG),
  localparam int TW   = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            iss_valid,
  input  logic [AW-1:0]   iss_dest,
  input  logic [PCW-1:0]  iss_pc,
  output logic            iss_ready,
  output logic [TW-1:0]   iss_tag,
  input  logic            cmp_valid,
  input  logic [TW-1:0]   cmp_tag,
  input  logic [DW-1:0]   cmp_value,
  input  logic            cmp_exc,
  input  logic [AW-1:0]   rd_addr,
  output logic [DW-1:0]   rd_data,
  input  logic [AW-1:0]   arch_addr,
  output logic [DW-1:0]   arch_data,
  output logic            cmt_valid,
  output logic [AW-1:0]   cmt_dest,
  output logic [DW-1:0]   cmt_value,
  output logic            flush_valid,
  output logic [PCW-1:0]  flush_pc
);
  logic              ff_we, commit_fire, flush_fire;
  logic [AW-1:0]     ff_waddr, commit_dest;
  logic [DW-1:0]     ff_wdata, commit_value, ff_rdata;
  logic [PCW-1:0]    head_pc;
  logic [TW:0]       q_count;
  logic [NREG*DW-1:0] arch_all, ff_all;

  ffrob_queue #(.NREG(NREG), .DW(DW), .DEPTH(DEPTH), .PCW(PCW)) u_q (
    .clk, .rst, .iss_valid, .iss_dest, .iss_pc, .iss_ready, .iss_tag,
    .cmp_valid, .cmp_tag, .cmp_value, .cmp_exc,
    .ff_we, .ff_waddr, .ff_wdata,
    .commit_fire, .commit_dest, .commit_value,
    .flush_fire, .flush_pc(head_pc), .count_q(q_count)
  );

  ffrob_regfile #(.NREG(NREG), .DW(DW)) u_arch (
    .clk, .rst, .we(commit_fire), .waddr(commit_dest), .wdata(commit_value),
    .load_en(1'b0), .load_all('0), .raddr(arch_addr), .rdata(arch_data),
    .all_q(arch_all)
  );

  ffrob_regfile #(.NREG(NREG), .DW(DW)) u_fut (
    .clk, .rst, .we(ff_we), .waddr(ff_waddr), .wdata(ff_wdata),
    .load_en(flush_fire), .load_all(arch_all), .raddr(rd_addr), .rdata(ff_rdata),
    .all_q(ff_all)
  );

  assign rd_data = (ff_we && (ff_waddr == rd_addr)) ? ff_wdata : ff_rdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmt_valid   <= 1'b0;
      cmt_dest    <= '0;
      cmt_value   <= '0;
      flush_valid <= 1'b0;
      flush_pc    <= '0;
    end else begin
      cmt_valid   <= commit_fire;
      flush_valid <= flush_fire;
      if (commit_fire) begin
        cmt_dest  <= commit_dest;
        cmt_value <= commit_value;
      end
      if (flush_fire) flush_pc <= head_pc;
    end
  end
endmodule

// File: rtl/ffrob_chk.sv
module ffrob_chk #(
  parameter int NREG  = 8,
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  localparam int TW   = $clog2(DEPTH)
) (
  input logic               clk,
  input logic               rst,
  input logic               cmt_valid,
  input logic               flush_valid,
  input logic               iss_ready,
  input logic               commit_fire,
  input logic [TW:0]        q_count,
  input logic [NREG*DW-1:0] arch_all,
  input logic [NREG*DW-1:0] ff_all
);
  // R6: retirement and flush never reported together
  a_r6_retire_xor_flush: assert property (@(posedge clk) disable iff (rst)
    !(cmt_valid && flush_valid));

  // R3: committed copy holds still unless a retirement happened
  a_r3_arch_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(commit_fire) |-> $stable(arch_all));

  // R7: after a flush both copies agree
  a_r7_copies_match: assert property (@(posedge clk) disable iff (rst)
    flush_valid |-> (ff_all == arch_all));

  // R7: after a flush the queue is empty and accepting
  a_r7_empty_after_flush: assert property (@(posedge clk) disable iff (rst)
    flush_valid |-> (iss_ready && (q_count == '0)));

  // R2: occupancy never exceeds capacity
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (rst)
    q_count <= (TW+1)'(DEPTH));
endmodule

bind future_file_rob ffrob_chk #(.NREG(NREG), .DW(DW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .cmt_valid(cmt_valid), .flush_valid(flush_valid),
  .iss_ready(iss_ready), .commit_fire(commit_fire), .q_count(q_count),
  .arch_all(arch_all), .ff_all(ff_all)
);

// File: tb/future_file_rob_tb_top.sv
`timescale 1ns/1ps
module future_file_rob_tb_top;
  localparam int NREG = 8, DW = 16, DEPTH = 8, PCW = 16;
  localparam int AW = $clog2(NREG), TW = $clog2(DEPTH);

  logic clk = 0, rst = 1;
  logic iss_valid = 0, cmp_valid = 0, cmp_exc = 0;
  logic [AW-1:0] iss_dest = '0, rd_addr = '0, arch_addr = '0;
  logic [PCW-1:0] iss_pc = '0;
  logic [TW-1:0] cmp_tag = '0;
  logic [DW-1:0] cmp_value = '0;
  logic iss_ready, cmt_valid, flush_valid;
  logic [TW-1:0] iss_tag;
  logic [DW-1:0] rd_data, arch_data, cmt_value;
  logic [AW-1:0] cmt_dest;
  logic [PCW-1:0] flush_pc;

  always #5 clk = ~clk;

  future_file_rob #(.NREG(NREG), .DW(DW), .DEPTH(DEPTH), .PCW(PCW)) dut_i (.*);

  int checks = 0, failures = 0, ncommit = 0, nflush = 0;
  logic [AW-1:0]  exp_dest [DEPTH];
  logic [PCW-1:0] exp_pc   [DEPTH];
  logic [DW-1:0]  exp_val  [DEPTH];
  logic           exp_exc  [DEPTH];
  logic [DW-1:0]  ref_arch [NREG];
  logic [TW-1:0]  order_q [$];

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [AW-1:0] d, input logic [PCW-1:0] pc,
                       output logic [TW-1:0] tag, output bit acc);
    @(negedge clk);
    iss_valid = 1; iss_dest = d; iss_pc = pc;
    #1 tag = iss_tag; acc = iss_ready;
    if (acc) begin exp_dest[tag] = d; exp_pc[tag] = pc; order_q.push_back(tag); end
    @(posedge clk); #1 iss_valid = 0;
  endtask

  task automatic complete(input logic [TW-1:0] t, input logic [DW-1:0] v, input bit e);
    @(negedge clk);
    cmp_valid = 1; cmp_tag = t; cmp_value = v; cmp_exc = e;
    exp_val[t] = v; exp_exc[t] = e;
    @(posedge clk); #1 cmp_valid = 0; cmp_exc = 0;
  endtask

  task automatic read_chk(input logic [AW-1:0] a, input logic [DW-1:0] e, string req);
    @(negedge clk); rd_addr = a; #1;
    chk(rd_data == e, req, $sformatf("rd_data r%0d", a), rd_data, e);
  endtask

  // Monitor / scoreboard: owns arch_addr
  initial begin
    @(negedge clk); wait (!rst); @(negedge clk);
    for (int r = 0; r < NREG; r++) begin
      arch_addr = AW'(r); #0.4;
      chk(arch_data == '0, "R1", "arch reset", arch_data, 0);
    end
    forever begin
      @(negedge clk);
      if (cmt_valid) begin
        if (order_q.size() == 0) chk(0, "R6", "unexpected retire", cmt_dest, 0);
        else begin
          automatic logic [TW-1:0] t = order_q.pop_front();
          chk(!exp_exc[t], "R6", "retired faulting entry", t, 0);
          chk(cmt_dest == exp_dest[t], "R6", "cmt_dest order", cmt_dest, exp_dest[t]);
          chk(cmt_value == exp_val[t], "R6", "cmt_value", cmt_value, exp_val[t]);
          ref_arch[cmt_dest] = cmt_value;
          arch_addr = cmt_dest; #1;
          chk(arch_data == ref_arch[cmt_dest], "R6", "arch after retire", arch_data, ref_arch[cmt_dest]);
        end
        ncommit++;
      end
      if (flush_valid) begin
        if (order_q.size() == 0) chk(0, "R7", "unexpected flush", flush_pc, 0);
        else begin
          automatic logic [TW-1:0] t = order_q.pop_front();
          chk(exp_exc[t], "R7", "flush of clean entry", t, 0);
          chk(flush_pc == exp_pc[t], "R7", "flush_pc", flush_pc, exp_pc[t]);
        end
        order_q.delete();
        nflush++;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "ALL", "watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [TW-1:0] tg, tags [8];
    bit acc;
    for (int r = 0; r < NREG; r++) ref_arch[r] = '0;
    repeat (3) @(posedge clk); #1 rst = 0;

    // R1: reset state
    @(negedge clk);
    chk(iss_ready == 1, "R1", "iss_ready", iss_ready, 1);
    chk(iss_tag == 0, "R1", "first tag", iss_tag, 0);
    chk(!cmt_valid && !flush_valid, "R1", "no retire/flush", {cmt_valid, flush_valid}, 0);
    for (int r = 0; r < NREG; r++) read_chk(AW'(r), '0, "R1");

    // R2: six issues, tags in order
    issue(2, 16'h10, tags[0], acc); issue(3, 16'h14, tags[1], acc);
    issue(2, 16'h18, tags[2], acc); issue(1, 16'h1C, tags[3], acc);
    issue(2, 16'h20, tags[4], acc); issue(0, 16'h24, tags[5], acc);
    for (int i = 0; i < 6; i++) chk(tags[i] == TW'(i), "R2", "tag order", tags[i], i);

    // R3: younger results visible while head pending
    complete(4, 16'hFD4F, 0);
    complete(3, 16'h02E7, 0);
    read_chk(1, 16'h02E7, "R3");
    read_chk(2, 16'hFD4F, "R3");
    chk(ncommit == 0, "R3", "no retire while head pending", ncommit, 0);
    // R5: older writer of r2 completes late
    complete(2, 16'h029B, 0);
    read_chk(2, 16'hFD4F, "R5");
    // R4: same-cycle bypass
    @(negedge clk);
    rd_addr = 3; cmp_valid = 1; cmp_tag = 1; cmp_value = 16'hFF9D; cmp_exc = 0;
    exp_val[1] = 16'hFF9D; exp_exc[1] = 0;
    #1 chk(rd_data == 16'hFF9D, "R4", "bypass r3", rd_data, 16'hFF9D);
    @(posedge clk); #1 cmp_valid = 0;
    complete(0, 16'hFFFB, 0);
    read_chk(2, 16'hFD4F, "R5");
    wait (ncommit == 5);
    repeat (4) @(negedge clk);
    chk(ncommit == 5, "R6", "stops at incomplete head", ncommit, 5);

    // R2: fill with wrap-around
    for (int i = 0; i < 7; i++) issue(AW'(i == 0 ? 4 : i + 4 > 7 ? i - 3 : i + 4), PCW'(16'h40 + 4*i), tags[i], acc);
    for (int i = 0; i < 7; i++) chk(tags[i] == TW'(6 + i), "R2", "wrapped tag", tags[i], (6 + i) % DEPTH);
    @(negedge clk);
    chk(iss_ready == 0, "R2", "full stalls issue", iss_ready, 0);
    issue(7, 16'h99, tg, acc);
    chk(!acc && iss_tag == tg && iss_ready == 0, "R2", "issue when full ignored", iss_tag, tg);

    for (int i = 1; i < 7; i++) complete(TW'(6 + i), DW'(16'h11 + i), 0);
    read_chk(5, 16'h12, "R3");
    chk(ncommit == 5, "R3", "no retire past pending head", ncommit, 5);
    complete(5, 16'h0036, 0);
    complete(6, 16'h0099, 1);
    wait (nflush == 1);
    for (int r = 0; r < NREG; r++) read_chk(AW'(r), ref_arch[r], "R7");
    chk(ref_arch[0] == 16'h0036 && ref_arch[1] == 16'h02E7, "R6", "reference retired F", ref_arch[0], 16'h36);
    @(negedge clk);
    chk(iss_ready == 1, "R7", "ready after flush", iss_ready, 1);
    issue(5, 16'h80, tg, acc);
    chk(acc && tg == 0, "R7", "tag restarts", tg, 0);

    // R8: completion into a free slot
    complete(3, 16'h0777, 0);
    repeat (3) @(negedge clk);
    for (int r = 0; r < NREG; r++) read_chk(AW'(r), ref_arch[r], "R8");
    chk(ncommit == 6, "R8", "no retire from stale slot", ncommit, 6);

    complete(0, 16'h0055, 0);
    wait (ncommit == 7);
    repeat (2) @(negedge clk);
    read_chk(5, 16'h0055, "R3");
    chk(order_q.size() == 0, "R6", "scoreboard drained", order_q.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule